// File: doc/BRIEF.md
# Dual-Mode Dual-Clock FIFO

This block is a first-in first-out buffer whose write port and read port run on unrelated clocks. Each port has its own active-low enable and its own status flag. The array depth is a parameter and the word width defaults to 18 bits. Each pointer crosses into the other clock domain as a gray code through a two-flop synchronizer. Each pointer is one bit wider than the array address, so a full array and an empty array can be told apart.

A mode input is captured while the master reset is held. It selects one of two read disciplines. In standard mode, every word must be requested with a read strobe. The write flag is low when the buffer is full, and the read flag is high when a word is available. In fall-through mode, the oldest word moves into the output register without any request. The write flag is high when no room remains, and the read flag is low while a valid word sits on the output. The output register counts as storage, so one extra word fits. The chosen mode stays fixed until the master reset is asserted again.

Top module: `dual_mode_fifo`

## Requirements
- R1: A word presented while `wen_n` is low at a rising `wclk` edge, with room available, is stored. Stored words leave on `dout` in the order they were written.
- R2: A write attempted while the write flag shows no room is discarded in both modes. It changes neither the stored contents nor the read-out sequence.
- R3: In standard mode (`mode_fwft` = 0 at reset), with no reads, `wr_flag` stays 1 for the first DEPTH-1 writes after reset and reads 0 once the DEPTH-th write has been taken.
- R4: In fall-through mode (`mode_fwft` = 1 at reset), with no reads, the read clock running and the first word already on the output, `wr_flag` stays 0 through DEPTH writes and becomes 1 after write number DEPTH+1.
- R5: In standard mode, `dout` changes only at a `rclk` edge with `ren_n` low while `rd_flag` is 1. A written word does not reach `dout` by itself. `rd_flag` returns to 0 after the last stored word is read, and a read strobe while `rd_flag` is 0 leaves `dout` unchanged.
- R6: In fall-through mode, a word written into an empty buffer appears on `dout` at the third rising `rclk` edge after the write edge, with `ren_n` held high. `rd_flag` falls to 0 at that same edge and not earlier.
- R7: In fall-through mode, `rd_flag` rises to 1 at the `rclk` edge where `ren_n` is low and the word on the output is the last one held.
- R8: While `ren_n` is high and a word is on the output, `dout` holds its value.
- R9: A flag released by activity on the other port moves in its own domain two clock edges after that activity. In standard mode, `rd_flag` rises after the second `rclk` edge following a write into an empty buffer. `wr_flag` leaves the full state after the second `wclk` edge following a read.
- R10: `mode_fwft` is sampled only while `mrst_n` is low. Changing it after reset release alters neither the flag polarity nor the read behaviour.
- R11: After reset, `dout` is 0 and the buffer is empty. In standard mode that shows as `wr_flag` = 1 and `rd_flag` = 0. In fall-through mode it shows as `wr_flag` = 0 and `rd_flag` = 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| mrst_n | input | 1 | Master reset, active low, asynchronous assertion |
| mode_fwft | input | 1 | Mode select captured during reset: 0 standard, 1 fall-through |
| wclk | input | 1 | Write clock |
| wen_n | input | 1 | Write enable, active low |
| din | input | DW | Write data |
| wr_flag | output | 1 | Standard: 0 when full. Fall-through: 1 when no room |
| rclk | input | 1 | Read clock |
| ren_n | input | 1 | Read enable, active low |
| dout | output | DW | Output data register |
| rd_flag | output | 1 | Standard: 1 when data available. Fall-through: 0 when output valid |

## Verification
The checker assumes that both clocks run while `mrst_n` is low, so that each domain captures the mode and clears its pointers before release. It also assumes that `mode_fwft` is steady across the release edge and that DEPTH is a power of two of at least four. The stimulus holds reset and mode for several edges of each clock and changes the mode only well after release. The two clock periods are chosen so that their rising edges never coincide. The edge counts in the latency requirements are therefore unambiguous, and each port's inputs change only on its own falling edges.

// File: rtl/dmf_pkg.sv
package dmf_pkg;

  typedef enum logic {
    MODE_STD  = 1'b0,
    MODE_FWFT = 1'b1
  } fifo_mode_e;

  localparam int unsigned SYNC_STAGES = 2;

endpackage

// File: rtl/dmf_rst_sync.sv
module dmf_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain_q <= '0;
    else         chain_q <= chain_d;
  end

  assign rst_n = chain_q[STAGES-1];

endmodule

// File: rtl/dmf_sync.sv
module dmf_sync #(
  parameter int unsigned W      = 4,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] stage_q [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stage_q[i] <= '0;
    end else begin
      stage_q[0] <= d;
      for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
    end
  end

  assign q = stage_q[STAGES-1];

endmodule

// File: rtl/dmf_ptr.sv
module dmf_ptr #(
  parameter int unsigned AW = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        inc,
  output logic [AW:0] bin,
  output logic [AW:0] gray
);

  logic [AW:0] bin_q, bin_d;
  logic [AW:0] gray_q, gray_d;

  always_comb begin
    bin_d  = bin_q + {{AW{1'b0}}, inc};
    gray_d = bin_d ^ (bin_d >> 1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bin_q  <= '0;
      gray_q <= '0;
    end else if (inc) begin
      bin_q  <= bin_d;
      gray_q <= gray_d;
    end
  end

  assign bin  = bin_q;
  assign gray = gray_q;

endmodule

// File: rtl/dmf_ram.sv
module dmf_ram #(
  parameter int unsigned DW    = 18,
  parameter int unsigned DEPTH = 16,
  parameter int unsigned AW    = 4
) (
  input  logic          wclk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);

  logic [DW-1:0] cell_q [DEPTH];

  always_ff @(posedge wclk) begin
    if (we) cell_q[waddr] <= wdata;
  end

  assign rdata = cell_q[raddr];

endmodule

// File: rtl/dual_mode_fifo.sv
module dual_mode_fifo
  import dmf_pkg::*;
#(
  parameter int unsigned DW    = 18,
  parameter int unsigned DEPTH = 16
) (
  input  logic          mrst_n,
  input  logic          mode_fwft,
  input  logic          wclk,
  input  logic          wen_n,
  input  logic [DW-1:0] din,
  output logic          wr_flag,
  input  logic          rclk,
  input  logic          ren_n,
  output logic [DW-1:0] dout,
  output logic          rd_flag
);

  localparam int unsigned AW = $clog2(DEPTH);
  localparam int unsigned PW = AW + 1;
  localparam logic [PW-1:0] FULL_XOR = {2'b11, {(PW-2){1'b0}}};

  // ---------------- reset release per domain ----------------
  logic wrst_n, rrst_n;

  dmf_rst_sync #(.STAGES(SYNC_STAGES)) u_wrst (.clk(wclk), .arst_n(mrst_n), .rst_n(wrst_n));
  dmf_rst_sync #(.STAGES(SYNC_STAGES)) u_rrst (.clk(rclk), .arst_n(mrst_n), .rst_n(rrst_n));

  // ---------------- mode capture (only while in reset) ----------------
  fifo_mode_e mode_w, mode_r;
  logic       mode_ld_w, mode_ld_r;

  assign mode_ld_w = ~wrst_n;
  assign mode_ld_r = ~rrst_n;

  always_ff @(posedge wclk) begin
    if (mode_ld_w) mode_w <= fifo_mode_e'(mode_fwft);
  end

  always_ff @(posedge rclk) begin
    if (mode_ld_r) mode_r <= fifo_mode_e'(mode_fwft);
  end

  // ---------------- write side ----------------
  logic [PW-1:0] wbin, wgray, rgray_w;
  logic          wr_full, wr_fire;

  assign wr_fire = ~wen_n & ~wr_full;

  dmf_ptr #(.AW(AW)) u_wptr (
    .clk (wclk),
    .rst_n (wrst_n),
    .inc (wr_fire),
    .bin (wbin),
    .gray(wgray)
  );

  dmf_sync #(.W(PW), .STAGES(SYNC_STAGES)) u_r2w (
    .clk (wclk),
    .rst_n(wrst_n),
    .d   (rgray),
    .q   (rgray_w)
  );

  assign wr_full = ((wgray ^ rgray_w) == FULL_XOR);
  assign wr_flag = (mode_w == MODE_FWFT) ? wr_full : ~wr_full;

  // ---------------- storage ----------------
  logic [PW-1:0] rbin, rgray, wgray_r;
  logic [DW-1:0] rdata;
  logic          rd_load;

  dmf_ram #(.DW(DW), .DEPTH(DEPTH), .AW(AW)) u_ram (
    .wclk (wclk),
    .we   (wr_fire),
    .waddr(wbin[AW-1:0]),
    .wdata(din),
    .raddr(rbin[AW-1:0]),
    .rdata(rdata)
  );

  // ---------------- read side ----------------
  logic mem_empty;
  logic ov_q, ov_d;

  dmf_sync #(.W(PW), .STAGES(SYNC_STAGES)) u_w2r (
    .clk (rclk),
    .rst_n(rrst_n),
    .d   (wgray),
    .q   (wgray_r)
  );

  dmf_ptr #(.AW(AW)) u_rptr (
    .clk (rclk),
    .rst_n (rrst_n),
    .inc (rd_load),
    .bin (rbin),
    .gray(rgray)
  );

  assign mem_empty = (rgray == wgray_r);

  always_comb begin
    rd_load = 1'b0;
    ov_d    = ov_q;
    if (mode_r == MODE_FWFT) begin
      rd_load = ~mem_empty & (~ov_q | ~ren_n);
      if (rd_load)     ov_d = 1'b1;
      else if (!ren_n) ov_d = 1'b0;
    end else begin
      rd_load = ~ren_n & ~mem_empty;
      ov_d    = 1'b0;
    end
  end

  always_ff @(posedge rclk or negedge rrst_n) begin
    if (!rrst_n) ov_q <= 1'b0;
    else         ov_q <= ov_d;
  end

  always_ff @(posedge rclk or negedge rrst_n) begin
    if (!rrst_n)      dout <= '0;
    else if (rd_load) dout <= rdata;
  end

  assign rd_flag = (mode_r == MODE_FWFT) ? ~ov_q : ~mem_empty;

endmodule

// File: rtl/dmf_chk.sv
module dmf_chk #(
  parameter int unsigned PW = 5,
  parameter int unsigned DW = 18
) (
  input logic                wclk,
  input logic                rclk,
  input logic                wrst_n,
  input logic                rrst_n,
  input logic                wen_n,
  input logic                ren_n,
  input logic                wr_full,
  input logic                mem_empty,
  input logic [PW-1:0]       wbin,
  input logic [PW-1:0]       rbin,
  input logic [DW-1:0]       dout,
  input logic                rd_flag,
  input dmf_pkg::fifo_mode_e mode_w,
  input dmf_pkg::fifo_mode_e mode_r
);

  // R2
  no_overflow_chk: assert property (@(posedge wclk) disable iff (!wrst_n)
    (wr_full && !wen_n) |=> $stable(wbin));

  // R5
  no_underflow_chk: assert property (@(posedge rclk) disable iff (!rrst_n)
    (mode_r == dmf_pkg::MODE_STD && mem_empty) |=> $stable(rbin));

  // R8
  std_hold_chk: assert property (@(posedge rclk) disable iff (!rrst_n)
    (mode_r == dmf_pkg::MODE_STD && ren_n) |=> $stable(dout));

  // R8
  fwft_hold_chk: assert property (@(posedge rclk) disable iff (!rrst_n)
    (mode_r == dmf_pkg::MODE_FWFT && !rd_flag && ren_n) |=> ($stable(dout) && !rd_flag));

  // R6
  fall_through_chk: assert property (@(posedge rclk) disable iff (!rrst_n)
    (mode_r == dmf_pkg::MODE_FWFT && rd_flag && !mem_empty) |=> !rd_flag);

  // R7
  last_word_chk: assert property (@(posedge rclk) disable iff (!rrst_n)
    (mode_r == dmf_pkg::MODE_FWFT && !rd_flag && !ren_n && mem_empty) |=> rd_flag);

  // R10
  mode_w_fixed_chk: assert property (@(posedge wclk) disable iff (!wrst_n)
    wrst_n |=> $stable(mode_w));

  // R10
  mode_r_fixed_chk: assert property (@(posedge rclk) disable iff (!rrst_n)
    rrst_n |=> $stable(mode_r));

endmodule

bind dual_mode_fifo dmf_chk #(.PW(PW), .DW(DW)) u_chk (
  .wclk     (wclk),
  .rclk     (rclk),
  .wrst_n   (wrst_n),
  .rrst_n   (rrst_n),
  .wen_n    (wen_n),
  .ren_n    (ren_n),
  .wr_full  (wr_full),
  .mem_empty(mem_empty),
  .wbin     (wbin),
  .rbin     (rbin),
  .dout     (dout),
  .rd_flag  (rd_flag),
  .mode_w   (mode_w),
  .mode_r   (mode_r)
);

// File: tb/dual_mode_fifo_bench.sv
module dual_mode_fifo_bench;

  localparam int DW = 18;
  localparam int D  = 16;

  logic          wclk, rclk, mrst_n, mode_fwft, wen_n, ren_n;
  logic [DW-1:0] din, dout;
  logic          wr_flag, rd_flag;

  int n_vec, n_bad, rcnt, wcnt;
  bit cur_fwft;
  logic [DW-1:0] exp_q [$];

  dual_mode_fifo #(.DW(DW), .DEPTH(D)) u_dual_mode_fifo (
    .mrst_n(mrst_n), .mode_fwft(mode_fwft),
    .wclk(wclk), .wen_n(wen_n), .din(din), .wr_flag(wr_flag),
    .rclk(rclk), .ren_n(ren_n), .dout(dout), .rd_flag(rd_flag)
  );

  // 50 MHz write clock: rising edges at even ns; read clock rising at odd ns
  initial begin wclk = 0; forever #10 wclk = ~wclk; end
  initial begin rclk = 0; forever #13 rclk = ~rclk; end

  always @(posedge rclk) rcnt++;
  always @(posedge wclk) wcnt++;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
  endtask

  task automatic do_reset(input bit fwft);
    mrst_n = 1'b0; mode_fwft = fwft; wen_n = 1'b1; ren_n = 1'b1; din = '0;
    cur_fwft = fwft;
    exp_q.delete();
    repeat (5) @(posedge rclk);
    @(negedge wclk) mrst_n = 1'b1;
    repeat (5) @(negedge rclk);
  endtask

  // driver: one write attempt; pushes the expected item when room was shown
  task automatic push_word(input logic [DW-1:0] w, output bit took, output int rstamp);
    @(negedge wclk);
    took = cur_fwft ? !wr_flag : wr_flag;
    din = w; wen_n = 1'b0;
    @(posedge wclk);
    rstamp = rcnt;
    @(negedge wclk);
    wen_n = 1'b1;
    if (took) exp_q.push_back(w);
  endtask

  // monitor: one read attempt, compares against the scoreboard queue
  task automatic pop_word(output bit got);
    logic [DW-1:0] e;
    @(negedge rclk);
    got = cur_fwft ? !rd_flag : rd_flag;
    if (got) begin
      e = (exp_q.size() > 0) ? exp_q.pop_front() : 'x;
      if (cur_fwft) check("R1 fwft order", dout, e);
      ren_n = 1'b0;
      @(negedge rclk);
      ren_n = 1'b1;
      if (!cur_fwft) check("R1 std order", dout, e);
    end
  endtask

  task automatic drain(input int max_iter);
    bit got;
    for (int i = 0; i < max_iter && exp_q.size() > 0; i++) pop_word(got);
    check("R1 queue drained", exp_q.size(), 0);
  endtask

  task automatic stream(input int n);
    fork
      begin
        bit took; int rs;
        for (int i = 0; i < n; i++) begin
          took = 1'b0;
          while (!took) push_word(DW'((i * 7919) ^ 18'h2B4C3), took, rs);
        end
      end
      begin
        bit got; int cnt;
        cnt = 0;
        while (cnt < n) begin
          pop_word(got);
          if (got) begin
            cnt++;
            if (cnt % 3 == 0) repeat (4) @(negedge rclk);
          end
        end
      end
    join
  endtask

  initial begin
    #1_000_000;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    bit took, got;
    int rs, ws;
    logic [DW-1:0] last;
    n_vec = 0; n_bad = 0; rcnt = 0; wcnt = 0;
    mrst_n = 1'b1; mode_fwft = 1'b0; wen_n = 1'b1; ren_n = 1'b1; din = '0;
    #2;

    // ===== standard mode =====
    do_reset(1'b0);
    check("R11 std wr_flag", wr_flag, 1);
    check("R11 std rd_flag", rd_flag, 0);
    check("R11 std dout", dout, 0);
    @(negedge wclk) mode_fwft = 1'b1;
    repeat (4) @(negedge rclk);
    check("R10 std wr_flag kept", wr_flag, 1);
    check("R10 std rd_flag kept", rd_flag, 0);

    // R9 read-side release latency, R5 no fall-through
    push_word(18'h2A5A5, took, rs);
    wait (rcnt >= rs + 1); @(negedge rclk);
    check("R9 empty after 1 rclk", rd_flag, 0);
    wait (rcnt >= rs + 2); @(negedge rclk);
    check("R9 data after 2 rclk", rd_flag, 1);
    repeat (3) @(negedge rclk);
    check("R5 no fall-through", dout, 0);
    pop_word(got);
    check("R5 empty after last read", rd_flag, 0);
    @(negedge rclk) ren_n = 1'b0;
    @(negedge rclk) ren_n = 1'b1;
    check("R5 read while empty ignored", dout, 18'h2A5A5);

    // R3 fill to exactly D, R2 overflow ignored
    for (int i = 0; i < D; i++) begin
      push_word(DW'(100 + i), took, rs);
      check("R3 full flag", wr_flag, (i == D - 1) ? 0 : 1);
    end
    push_word(18'h3FFFF, took, rs);
    check("R2 std write while full refused", took, 0);
    check("R2 std still full", wr_flag, 0);

    // R9 write-side release latency on first read
    @(negedge rclk) ren_n = 1'b0;
    @(posedge rclk) ws = wcnt;
    fork
      begin @(negedge rclk) ren_n = 1'b1; end
      begin
        wait (wcnt >= ws + 1); @(negedge wclk);
        check("R9 full after 1 wclk", wr_flag, 0);
        wait (wcnt >= ws + 2); @(negedge wclk);
        check("R9 room after 2 wclk", wr_flag, 1);
      end
    join
    last = exp_q.pop_front();
    check("R1 first of fill", dout, last);
    repeat (3) @(negedge rclk);
    check("R8 std hold", dout, last);
    drain(40);
    check("R5 empty after drain", rd_flag, 0);
    @(negedge rclk) ren_n = 1'b0;
    @(negedge rclk) ren_n = 1'b1;
    check("R2 overflow word absent", dout, DW'(100 + D - 1));

    stream(30);

    // ===== fall-through mode =====
    do_reset(1'b1);
    @(negedge wclk) mode_fwft = 1'b0;
    repeat (4) @(negedge rclk);
    check("R11 fwft wr_flag", wr_flag, 0);
    check("R11 fwft rd_flag", rd_flag, 1);
    check("R11 fwft dout", dout, 0);
    check("R10 fwft polarity kept", {wr_flag, rd_flag}, 2'b01);

    push_word(18'h15555, took, rs);
    wait (rcnt >= rs + 2); @(negedge rclk);
    check("R6 not yet after 2 rclk", rd_flag, 1);
    check("R6 dout not yet", dout, 0);
    wait (rcnt >= rs + 3); @(negedge rclk);
    check("R6 valid at 3rd rclk", rd_flag, 0);
    check("R6 word fell through", dout, 18'h15555);
    repeat (3) @(negedge rclk);
    check("R8 fwft hold", dout, 18'h15555);
    @(negedge rclk) ren_n = 1'b0;
    @(negedge rclk) ren_n = 1'b1;
    check("R7 no data after last read", rd_flag, 1);
    exp_q.delete();

    // R4 capacity D+1
    push_word(DW'(200), took, rs);
    repeat (5) @(negedge rclk);
    check("R4 first word on output", rd_flag, 0);
    for (int i = 1; i <= D; i++) begin
      push_word(DW'(200 + i), took, rs);
      check("R4 input-ready flag", wr_flag, (i == D) ? 1 : 0);
    end
    push_word(18'h3FFFF, took, rs);
    check("R2 fwft write while full refused", took, 0);
    drain(40);
    repeat (2) @(negedge rclk);
    check("R7 no data after drain", rd_flag, 1);
    check("R2 fwft last word", dout, DW'(200 + D));

    stream(30);

    summary();
    $finish;
  end

endmodule